// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block runs one complete page-program operation against an 8-bit NAND device that sits behind a memory-mapped controller. A single start pulse launches the whole operation. The block sends the load-data command, then the column and row address bytes, then the main data in 512-byte chunks and the spare-area bytes. It closes with the program-confirm command. It then polls the controller's ready indication, reads the device status byte and reports success, a program failure or a ready timeout.

Every byte placed on the bus carries an offset that tells the bus controller what kind of cycle it is. This offset is what the neighbouring controller decodes to drive its command-latch and address-latch lines. Main-data and spare bytes are pulled from two upstream byte sources through request strobes. Each source must present its next byte combinationally in the cycle of its request. The spare stream is either appended after all the main data or interleaved, so that each 512-byte chunk is followed at once by its own 16 spare bytes.

The pin-level timing of the bus and the computation of ECC bytes belong to other blocks. Each bus beat here takes exactly one clock.

Top module: `nand_prog_seq`

## Requirements
- R1: Every bus write beat (`bus_we_o` high) carries offset 0x10 for a command byte, 0x08 for an address byte and 0x00 for a data or spare byte. No other offset is used, and a write beat and a read beat never coincide.
- R2: After an accepted start, the first beat is command 0x80. It is followed by the column bytes, all 0x00: one byte when `page_size_i` is 0 (512-byte page) and two bytes for codes 1 (2048), 2 (4096) and 3 (treated as 4096).
- R3: The row bytes follow the column bytes. They are page bits 7:0, then page bits 15:8. A third byte with bits 23:16 is added when the effective count is non-zero, and a fourth byte with bits 31:24 is added when the effective count equals 2. The effective count is `addr_cycles_i` minus one for a 512-byte page, and `addr_cycles_i` itself otherwise, taken modulo 8.
- R4: In append mode (`interleave_i` low), the block sends 1, 4 or 8 chunks of 512 main-data bytes for page codes 0, 1 and 2. These are followed by 16, 64 or 128 spare bytes. Each byte is taken from its source in the cycle where the matching request strobe is high.
- R5: In interleaved mode, each 512-byte data chunk is followed immediately by 16 spare bytes. Nothing follows the last chunk's spare bytes except the confirm command.
- R6: A spare beat whose `spare_keep_i` is low is sent as 0xFF, whatever value `spare_byte_i` holds.
- R7: The confirm command 0x10 directly follows the last spare byte. From then on, bit 0 of `ctl_status_i` is sampled once every POLL_GAP cycles. With ready high at the first sample, the status command 0x70 goes out POLL_GAP+1 cycles after the confirm beat.
- R8: If ready is low at all POLL_TRIES samples, `done_o` pulses POLL_TRIES*POLL_GAP+1 cycles after the confirm beat. `timeout_o` is set, and no status command or read beat is issued.
- R9: After the status command, one read beat (`bus_rd_o`) samples `rd_data_i`. `fail_o` is set exactly when bit 0 of that byte is 1, and the other bits are ignored.
- R10: `done_o` is a single-cycle pulse at the end of every operation. `timeout_o` and `fail_o` are never both set. Both flags hold their value until the next accepted start clears them.
- R11: A start pulse during an operation is ignored. Configuration or page inputs that change during an operation do not affect it, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| page_i | input | PAGE_W | Page number (row address) |
| page_size_i | input | 2 | 0 = 512, 1 = 2048, 2 or 3 = 4096 bytes |
| addr_cycles_i | input | 3 | Configured address cycle count |
| interleave_i | input | 1 | 1 = spare chunk after each data chunk |
| data_byte_i | input | 8 | Main-data byte for the current request |
| data_req_o | output | 1 | Main-data byte consumed this cycle |
| spare_byte_i | input | 8 | Spare byte for the current request |
| spare_keep_i | input | 1 | 1 = send spare_byte_i, 0 = send 0xFF |
| spare_req_o | output | 1 | Spare byte consumed this cycle |
| bus_we_o | output | 1 | Write beat on the NAND bus |
| bus_rd_o | output | 1 | Read beat on the NAND bus |
| bus_off_o | output | 8 | Cycle kind offset: 0x10 command, 0x08 address, 0x00 data |
| bus_byte_o | output | 8 | Byte written on a write beat |
| rd_data_i | input | 8 | Byte returned on a read beat |
| ctl_status_i | input | STAT_W | Controller status word, bit 0 = ready |
| done_o | output | 1 | End-of-operation pulse |
| timeout_o | output | 1 | Ready never seen, held until next start |
| fail_o | output | 1 | Device reported program failure, held until next start |

## Verification
A wrong address-index or chunk-counter state shows up as a shifted or missing byte in the recorded bus stream. This appears within one beat of the error, well before the confirm command, so the bench compares every beat of each operation against a stream it builds from the requirements. A wrong poll counter shows only as a shift in the gap between the confirm beat and the status command or the done pulse, which is why those distances are measured to the exact cycle in both the ready case and the timeout case. Mishandling of the flags or of the busy state shows at `done_o`, `timeout_o` and `fail_o` in the cycle the operation ends, and in the idle cycles after it.

// File: rtl/nps_pkg.sv
// Shared constants and types for the NAND page program sequencer.
// Assumes an 8-bit NAND bus whose controller decodes the cycle kind from an offset.
package nps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEQIN,
        ST_ADDR,
        ST_DATA,
        ST_SPARE,
        ST_CONFIRM,
        ST_POLL,
        ST_STATCMD,
        ST_STATRD,
        ST_FINISH
    } nps_state_e;

    // Offsets decoded by the bus controller into latch-line levels
    localparam logic [7:0] OFF_CMD  = 8'h10;
    localparam logic [7:0] OFF_ADDR = 8'h08;
    localparam logic [7:0] OFF_DATA = 8'h00;

    // NAND command codes
    localparam logic [7:0] CMD_LOAD    = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'h10;
    localparam logic [7:0] CMD_STATUS  = 8'h70;

endpackage

// File: rtl/nps_addr_plan.sv
// Address plan: works out how many address bytes an operation needs and
// which byte goes out at a given address index.
// Assumes PAGE_W <= 32; column bytes are always zero (start of page).
module nps_addr_plan #(
    parameter int PAGE_W = 32
) (
    input  logic [1:0]        size_code,
    input  logic [2:0]        acyc,
    input  logic [PAGE_W-1:0] page,
    input  logic [2:0]        idx,
    output logic [2:0]        total,
    output logic [7:0]        abyte
);

    logic [31:0] page32;
    logic        small_pg;
    logic [2:0]  col_n;
    logic [2:0]  eff;
    logic [2:0]  row_n;
    logic [1:0]  ridx;

    assign page32   = 32'(page);
    assign small_pg = (size_code == 2'd0);

    // Column/row byte counts and the byte for the current index
    always_comb begin
        col_n = small_pg ? 3'd1 : 3'd2;
        eff   = acyc - {2'b00, small_pg};
        row_n = 3'd2 + {2'b00, (eff != 3'd0)} + {2'b00, (eff == 3'd2)};
        total = col_n + row_n;
        ridx  = 2'(idx - col_n);
        abyte = 8'h00;
        if (idx >= col_n) begin
            abyte = page32[{ridx, 3'b000} +: 8];
        end
    end

endmodule

// File: rtl/nps_stream_cnt.sv
// Stream counters: track the byte position inside the current data chunk
// and spare chunk, and which chunk is current for each stream.
// Assumes CHUNK_BYTES and SPARE_CHUNK are powers of two above one.
module nps_stream_cnt #(
    parameter int CHUNK_BYTES = 512,
    parameter int SPARE_CHUNK = 16,
    parameter int MAX_CHUNKS  = 8,
    localparam int CI_W       = $clog2(MAX_CHUNKS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            d_step,
    input  logic            s_step,
    input  logic [CI_W-1:0] chunks,
    output logic            d_end,
    output logic            d_last,
    output logic            s_end,
    output logic            s_last
);

    localparam int DB_W = $clog2(CHUNK_BYTES);
    localparam int SB_W = $clog2(SPARE_CHUNK);

    logic [DB_W-1:0] d_cnt;
    logic [SB_W-1:0] s_cnt;
    logic [CI_W-1:0] d_chk;
    logic [CI_W-1:0] s_chk;

    assign d_end  = (d_cnt == DB_W'(CHUNK_BYTES - 1));
    assign s_end  = (s_cnt == SB_W'(SPARE_CHUNK - 1));
    assign d_last = (d_chk == chunks - CI_W'(1));
    assign s_last = (s_chk == chunks - CI_W'(1));

    // Main-data byte and chunk position
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            d_cnt <= '0;
            d_chk <= '0;
        end else if (d_step) begin
            if (d_end) begin
                d_cnt <= '0;
                d_chk <= d_chk + CI_W'(1);
            end else begin
                d_cnt <= d_cnt + DB_W'(1);
            end
        end
    end

    // Spare byte and chunk position
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s_cnt <= '0;
            s_chk <= '0;
        end else if (s_step) begin
            if (s_end) begin
                s_cnt <= '0;
                s_chk <= s_chk + CI_W'(1);
            end else begin
                s_cnt <= s_cnt + SB_W'(1);
            end
        end
    end

endmodule

// File: rtl/nps_poll_timer.sv
// Ready poll timer: while run is high, samples the ready bit every GAP
// cycles and gives up after TRIES samples without seeing ready.
// Assumes run stays high until hit or expire is acted on.
module nps_poll_timer #(
    parameter int GAP   = 4,
    parameter int TRIES = 101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rdy,
    output logic hit,
    output logic expire
);

    localparam int TW = $clog2(TRIES + 1);

    logic          sample;
    logic [TW-1:0] tries_q;

    generate
        if (GAP == 1) begin : g_every
            assign sample = run;
        end else begin : g_gap
            localparam int GW = $clog2(GAP);
            logic [GW-1:0] gap_q;
            assign sample = run && (gap_q == GW'(GAP - 1));
            // Interval counter between two samples
            always_ff @(posedge clk) begin
                if (!rst_n || !run || sample) begin
                    gap_q <= '0;
                end else begin
                    gap_q <= gap_q + GW'(1);
                end
            end
        end
    endgenerate

    // Number of samples already taken in this wait
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tries_q <= '0;
        end else if (sample) begin
            tries_q <= tries_q + TW'(1);
        end
    end

    assign hit    = sample && rdy;
    assign expire = sample && !rdy && (tries_q == TW'(TRIES - 1));

endmodule

// File: rtl/nand_prog_seq.sv
// NAND page program sequencer top: runs load command, address bytes, data
// and spare streams, confirm, ready poll and status check for one page.
// Assumes sources answer requests combinationally and the bus takes one
// beat per clock; ECC bytes arrive ready-made through the spare stream.
module nand_prog_seq
    import nps_pkg::*;
#(
    parameter int          PAGE_W      = 32,
    parameter int          STAT_W      = 32,
    parameter int          CHUNK_BYTES = 512,
    parameter int          SPARE_CHUNK = 16,
    parameter int          MAX_CHUNKS  = 8,
    parameter int          POLL_GAP    = 4,
    parameter int          POLL_TRIES  = 101,
    parameter logic [7:0]  FAIL_MASK   = 8'h01,
    parameter logic [STAT_W-1:0] READY_MASK = STAT_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [1:0]        page_size_i,
    input  logic [2:0]        addr_cycles_i,
    input  logic              interleave_i,
    input  logic [7:0]        data_byte_i,
    output logic              data_req_o,
    input  logic [7:0]        spare_byte_i,
    input  logic              spare_keep_i,
    output logic              spare_req_o,
    output logic              bus_we_o,
    output logic              bus_rd_o,
    output logic [7:0]        bus_off_o,
    output logic [7:0]        bus_byte_o,
    input  logic [7:0]        rd_data_i,
    input  logic [STAT_W-1:0] ctl_status_i,
    output logic              done_o,
    output logic              timeout_o,
    output logic              fail_o
);

    localparam int CI_W = $clog2(MAX_CHUNKS + 1);

    nps_state_e        state;
    logic [1:0]        ps_q;
    logic [2:0]        ac_q;
    logic              il_q;
    logic [PAGE_W-1:0] page_q;
    logic [2:0]        addr_idx;
    logic              to_q;
    logic              fail_q;

    logic [2:0]        addr_total;
    logic [7:0]        addr_byte;
    logic [CI_W-1:0]   chunks;
    logic              d_end, d_last, s_end, s_last;
    logic              poll_hit, poll_expire;
    logic              ready_bit;

    // Chunk count for the latched page size
    always_comb begin
        unique case (ps_q)
            2'd0:    chunks = CI_W'(1);
            2'd1:    chunks = CI_W'(MAX_CHUNKS / 2);
            default: chunks = CI_W'(MAX_CHUNKS);
        endcase
    end

    assign ready_bit = |(ctl_status_i & READY_MASK);

    nps_addr_plan #(.PAGE_W(PAGE_W)) u_addr (
        .size_code (ps_q),
        .acyc      (ac_q),
        .page      (page_q),
        .idx       (addr_idx),
        .total     (addr_total),
        .abyte     (addr_byte)
    );

    nps_stream_cnt #(
        .CHUNK_BYTES (CHUNK_BYTES),
        .SPARE_CHUNK (SPARE_CHUNK),
        .MAX_CHUNKS  (MAX_CHUNKS)
    ) u_stream (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == ST_IDLE),
        .d_step (state == ST_DATA),
        .s_step (state == ST_SPARE),
        .chunks (chunks),
        .d_end  (d_end),
        .d_last (d_last),
        .s_end  (s_end),
        .s_last (s_last)
    );

    nps_poll_timer #(.GAP(POLL_GAP), .TRIES(POLL_TRIES)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_POLL),
        .rdy    (ready_bit),
        .hit    (poll_hit),
        .expire (poll_expire)
    );

    // Operation sequencing, configuration latch and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ps_q     <= '0;
            ac_q     <= '0;
            il_q     <= 1'b0;
            page_q   <= '0;
            addr_idx <= '0;
            to_q     <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        ps_q     <= page_size_i;
                        ac_q     <= addr_cycles_i;
                        il_q     <= interleave_i;
                        page_q   <= page_i;
                        addr_idx <= '0;
                        to_q     <= 1'b0;
                        fail_q   <= 1'b0;
                        state    <= ST_SEQIN;
                    end
                end
                ST_SEQIN: state <= ST_ADDR;
                ST_ADDR: begin
                    if (addr_idx == addr_total - 3'd1) begin
                        state <= ST_DATA;
                    end else begin
                        addr_idx <= addr_idx + 3'd1;
                    end
                end
                ST_DATA: begin
                    if (d_end && (il_q || d_last)) begin
                        state <= ST_SPARE;
                    end
                end
                ST_SPARE: begin
                    if (s_end) begin
                        if (s_last) begin
                            state <= ST_CONFIRM;
                        end else if (il_q) begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_CONFIRM: state <= ST_POLL;
                ST_POLL: begin
                    if (poll_hit) begin
                        state <= ST_STATCMD;
                    end else if (poll_expire) begin
                        to_q  <= 1'b1;
                        state <= ST_FINISH;
                    end
                end
                ST_STATCMD: state <= ST_STATRD;
                ST_STATRD: begin
                    fail_q <= |(rd_data_i & FAIL_MASK);
                    state  <= ST_FINISH;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Bus beat contents for the current state
    always_comb begin
        bus_off_o  = OFF_DATA;
        bus_byte_o = 8'h00;
        unique case (state)
            ST_SEQIN: begin
                bus_off_o  = OFF_CMD;
                bus_byte_o = CMD_LOAD;
            end
            ST_ADDR: begin
                bus_off_o  = OFF_ADDR;
                bus_byte_o = addr_byte;
            end
            ST_DATA:  bus_byte_o = data_byte_i;
            ST_SPARE: bus_byte_o = spare_keep_i ? spare_byte_i : 8'hFF;
            ST_CONFIRM: begin
                bus_off_o  = OFF_CMD;
                bus_byte_o = CMD_CONFIRM;
            end
            ST_STATCMD: begin
                bus_off_o  = OFF_CMD;
                bus_byte_o = CMD_STATUS;
            end
            default: ;
        endcase
    end

    assign bus_we_o    = (state == ST_SEQIN) || (state == ST_ADDR) ||
                         (state == ST_DATA)  || (state == ST_SPARE) ||
                         (state == ST_CONFIRM) || (state == ST_STATCMD);
    assign bus_rd_o    = (state == ST_STATRD);
    assign data_req_o  = (state == ST_DATA);
    assign spare_req_o = (state == ST_SPARE);
    assign done_o      = (state == ST_FINISH);
    assign timeout_o   = to_q;
    assign fail_o      = fail_q;

endmodule

// File: rtl/nps_checker.sv
// Port-level protocol checks for the page program sequencer, bound to it.
// Assumes the default FAIL_MASK (status bit 0).
module nps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       data_req_o,
    input logic       spare_req_o,
    input logic       spare_keep_i,
    input logic       bus_we_o,
    input logic       bus_rd_o,
    input logic [7:0] bus_off_o,
    input logic [7:0] bus_byte_o,
    input logic [7:0] rd_data_i,
    input logic       done_o,
    input logic       timeout_o,
    input logic       fail_o
);

    assert_offset_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |-> (bus_off_o == 8'h10 || bus_off_o == 8'h08 || bus_off_o == 8'h00));

    assert_no_we_rd_clash_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_o && bus_rd_o));

    assert_stream_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req_o || spare_req_o) |-> (bus_we_o && bus_off_o == 8'h00 && !(data_req_o && spare_req_o)));

    assert_spare_filler_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_req_o && !spare_keep_i) |-> (bus_byte_o == 8'hFF));

    assert_fail_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_o |=> (fail_o == $past(rd_data_i[0]) && done_o));

    assert_timeout_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> done_o);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout_o && fail_o));

    assert_flag_clear_by_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(timeout_o) || $fell(fail_o)) |-> $past(start_i));

endmodule

bind nand_prog_seq nps_checker u_nps_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .data_req_o   (data_req_o),
    .spare_req_o  (spare_req_o),
    .spare_keep_i (spare_keep_i),
    .bus_we_o     (bus_we_o),
    .bus_rd_o     (bus_rd_o),
    .bus_off_o    (bus_off_o),
    .bus_byte_o   (bus_byte_o),
    .rd_data_i    (rd_data_i),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .fail_o       (fail_o)
);

// File: tb/nand_prog_seq_tb.sv
`timescale 1ns/1ps
// Directed bench: each scenario task runs one page program and checks the
// recorded bus stream, flags and timing against values built here.
module nand_prog_seq_tb;

    localparam int GAP   = 4;
    localparam int TRIES = 101;
    localparam int LOGSZ = 4400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] page_i = '0;
    logic [1:0]  page_size_i = '0;
    logic [2:0]  addr_cycles_i = '0;
    logic        interleave_i = 1'b0;
    logic [7:0]  data_byte_i;
    logic        data_req_o;
    logic [7:0]  spare_byte_i;
    logic        spare_keep_i;
    logic        spare_req_o;
    logic        bus_we_o, bus_rd_o;
    logic [7:0]  bus_off_o, bus_byte_o;
    logic [7:0]  rd_data_i = 8'h00;
    logic [31:0] ctl_status_i = 32'h0;
    logic        done_o, timeout_o, fail_o;

    int errors = 0;
    int checks = 0;
    int dcnt = 0, scnt = 0, cyc = 0, nlog = 0, done_cnt = 0, done_cyc = 0, rd_cnt = 0;
    bit keep_all = 1'b1;

    logic [15:0] lg [0:LOGSZ-1];
    int          lgc [0:LOGSZ-1];
    logic [15:0] ex [0:LOGSZ-1];
    int          nex;

    nand_prog_seq #(.POLL_GAP(GAP), .POLL_TRIES(TRIES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
        .page_size_i(page_size_i), .addr_cycles_i(addr_cycles_i),
        .interleave_i(interleave_i), .data_byte_i(data_byte_i),
        .data_req_o(data_req_o), .spare_byte_i(spare_byte_i),
        .spare_keep_i(spare_keep_i), .spare_req_o(spare_req_o),
        .bus_we_o(bus_we_o), .bus_rd_o(bus_rd_o), .bus_off_o(bus_off_o),
        .bus_byte_o(bus_byte_o), .rd_data_i(rd_data_i),
        .ctl_status_i(ctl_status_i), .done_o(done_o),
        .timeout_o(timeout_o), .fail_o(fail_o)
    );

    always #2 clk = ~clk;

    // Byte sources: patterns indexed by bytes already consumed
    assign data_byte_i  = 8'(dcnt * 7 + 3);
    assign spare_byte_i = 8'(scnt) ^ 8'hA0;
    assign spare_keep_i = keep_all || (scnt % 3 != 2);

    // Bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (bus_we_o && nlog < LOGSZ) begin
            lg[nlog]  = {bus_off_o, bus_byte_o};
            lgc[nlog] = cyc;
            nlog++;
        end
        if (data_req_o)  dcnt++;
        if (spare_req_o) scnt++;
        if (done_o) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if (bus_rd_o) rd_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] o, input logic [7:0] b);
        ex[nex] = {o, b};
        nex++;
    endtask

    // Expected bus stream from the requirements
    task automatic build(input logic [1:0] ps, input logic [2:0] ac, input bit il,
                         input logic [31:0] page, input bit keep, input bit exp_to);
        int chunks, dc, sc;
        logic [2:0] eff;
        nex = 0; dc = 0; sc = 0;
        push(8'h10, 8'h80);
        push(8'h08, 8'h00);
        if (ps != 2'd0) push(8'h08, 8'h00);
        eff = ac - ((ps == 2'd0) ? 3'd1 : 3'd0);
        push(8'h08, page[7:0]);
        push(8'h08, page[15:8]);
        if (eff != 3'd0) push(8'h08, page[23:16]);
        if (eff == 3'd2) push(8'h08, page[31:24]);
        chunks = (ps == 2'd0) ? 1 : (ps == 2'd1) ? 4 : 8;
        for (int c = 0; c < chunks; c++) begin
            for (int i = 0; i < 512; i++) begin
                push(8'h00, 8'(dc * 7 + 3));
                dc++;
            end
            if (il || c == chunks - 1) begin
                for (int i = 0; i < (il ? 16 : 16 * chunks); i++) begin
                    push(8'h00, (keep || sc % 3 != 2) ? (8'(sc) ^ 8'hA0) : 8'hFF);
                    sc++;
                end
            end
        end
        push(8'h10, 8'h10);
        if (!exp_to) push(8'h10, 8'h70);
    endtask

    task automatic run_op(input string req, input logic [1:0] ps, input logic [2:0] ac,
                          input bit il, input logic [31:0] page, input bit keep,
                          input bit rdy, input logic [7:0] stat, input bit extra_start);
        int n, mism, ci;
        bit exp_to, exp_fail;
        exp_to   = !rdy;
        exp_fail = !exp_to && stat[0];
        @(negedge clk);
        nlog = 0; dcnt = 0; scnt = 0; done_cnt = 0; rd_cnt = 0;
        keep_all = keep;
        ctl_status_i = rdy ? 32'hDEAD_BEE1 : 32'hDEAD_BEE0;
        rd_data_i = stat;
        page_i = page; page_size_i = ps; addr_cycles_i = ac; interleave_i = il;
        build(ps, ac, il, page, keep, exp_to);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
            if (extra_start && n == 30) begin
                start_i = 1'b1;
                page_size_i = 2'd2;
                page_i = 32'hFFFF_FFFF;
                interleave_i = ~il;
            end else begin
                start_i = 1'b0;
            end
        end
        chk(n < 20000, req, "operation finished", n, 20000);
        @(negedge clk);
        chk(nlog == nex, req, "bus beat count", nlog, nex);
        mism = -1;
        for (int i = 0; i < nex && i < nlog; i++) begin
            if (mism < 0 && lg[i] !== ex[i]) mism = i;
        end
        if (mism >= 0)
            chk(1'b0, req, $sformatf("beat %0d", mism), lg[mism], ex[mism]);
        else
            chk(1'b1, req, "beat contents", 0, 0);
        chk(timeout_o == exp_to, "R8", "timeout flag", timeout_o, exp_to);
        chk(fail_o == exp_fail, "R9", "fail flag", fail_o, exp_fail);
        chk(rd_cnt == (exp_to ? 0 : 1), "R9", "read beats", rd_cnt, exp_to ? 0 : 1);
        chk(done_cnt == 1 && !done_o, "R10", "single done pulse", done_cnt, 1);
        if (nlog == nex) begin
            ci = exp_to ? nex - 1 : nex - 2;
            if (exp_to)
                chk(done_cyc - lgc[ci] == TRIES * GAP + 1, "R8", "confirm to done",
                    done_cyc - lgc[ci], TRIES * GAP + 1);
            else
                chk(lgc[ci + 1] - lgc[ci] == GAP + 1, "R7", "confirm to status cmd",
                    lgc[ci + 1] - lgc[ci], GAP + 1);
        end
    endtask

    task automatic t_reset();
        chk(!done_o && !bus_we_o && !bus_rd_o, "R10", "idle outputs after reset",
            {done_o, bus_we_o, bus_rd_o}, 0);
        chk(!timeout_o && !fail_o, "R10", "flags after reset", {timeout_o, fail_o}, 0);
        chk(!data_req_o && !spare_req_o, "R4", "no requests after reset",
            {data_req_o, spare_req_o}, 0);
    endtask

    // Small page, four row bytes (R2, R3, R4)
    task automatic t_small_append();
        run_op("R3", 2'd0, 3'd3, 1'b0, 32'h1234_5678, 1'b1, 1'b1, 8'hE0, 1'b0);
    endtask

    // Large page, three row bytes, partial spare fill (R6)
    task automatic t_large_filler();
        run_op("R6", 2'd1, 3'd5, 1'b0, 32'hA1B2_C3D4, 1'b0, 1'b1, 8'h00, 1'b0);
    endtask

    // Large page, interleaved, two row bytes (R5)
    task automatic t_interleave();
        run_op("R5", 2'd1, 3'd0, 1'b1, 32'h0055_AA01, 1'b1, 1'b1, 8'h80, 1'b0);
    endtask

    // Largest page, appended (R4)
    task automatic t_big_append();
        run_op("R4", 2'd2, 3'd4, 1'b0, 32'h7654_3210, 1'b0, 1'b1, 8'h00, 1'b0);
    endtask

    // Largest page, interleaved (R5)
    task automatic t_big_interleave();
        run_op("R5", 2'd3, 3'd2, 1'b1, 32'h0F0E_0D0C, 1'b1, 1'b1, 8'h00, 1'b0);
    endtask

    // Program failure reported and held while idle (R9, R10)
    task automatic t_fail_hold();
        run_op("R9", 2'd0, 3'd4, 1'b0, 32'h0000_BEEF, 1'b1, 1'b1, 8'hC1, 1'b0);
        repeat (10) @(negedge clk);
        chk(fail_o && !timeout_o, "R10", "fail flag held while idle", fail_o, 1);
    endtask

    // Ready never seen (R8); previous fail flag cleared by the start
    task automatic t_timeout();
        run_op("R8", 2'd0, 3'd2, 1'b0, 32'h0102_0304, 1'b1, 1'b0, 8'h01, 1'b0);
    endtask

    // Start and new config while busy ignored (R11)
    task automatic t_busy_start();
        run_op("R11", 2'd0, 3'd3, 1'b0, 32'h00C0_FFEE, 1'b1, 1'b1, 8'h00, 1'b1);
        repeat (40) @(negedge clk);
        chk(nlog == nex && done_cnt == 1, "R11", "no second operation", nlog, nex);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_append();
        t_large_filler();
        t_interleave();
        t_big_append();
        t_big_interleave();
        t_fail_hold();
        t_timeout();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule